// File: doc/BRIEF.md
# Dual-Channel PS/2 Register Front End

This block puts a small register file in front of two PS/2 channels, channel 0 for a keyboard and channel 1 for a mouse. The channels sit in neighbouring 256-byte windows of one address space, and each window has the same four registers. The serial clock and data signalling on the cable belongs to separate device-side logic. This block only moves bytes. Received bytes come from a device-side queue through a valid/ready stream. Bytes to send leave as a one-cycle strobe.

The bus is single-cycle and byte-wide. Read data is combinational: it is valid in the same cycle as `bus_rd`. Side effects take place at the closing clock edge of that cycle. These side effects are popping the queue, draining the loopback byte and loading the control register.

Each channel can be put in loopback mode. In that mode a transmitted byte is caught in a one-byte buffer and comes back on the next receive read. A diagnostic mode reports the commanded line directions in the status register. One interrupt pin combines the requests of both channels, and both status registers show its level.

Top module: `ps2_dual_regfront`

## Requirements
- R1: Address bit 8 selects the channel (0 = keyboard, 1 = mouse). Address bits [3:2] select the register. Bits [7:4] and [1:0] are ignored. Register offsets are: 0x0 identity on read and channel reset on write; 0x4 receive data on read and transmit data on write; 0x8 control on read and write; 0xC status, read only.
- R2: The identity register reads 0x00 in the keyboard window and 0x01 in the mouse window.
- R3: The control register reads back the last byte written to it. Control bits are: 0 enable, 1 loopback, 5 diagnostic, 6 data direction, 7 clock direction. A write of any value to offset 0x0, or `rst_n` low, clears the control register and the loopback-full flag of that channel.
- R4: With loopback set, a transmit write stores the byte in the loopback buffer and sets the loopback-full flag. `tx_valid` stays low.
- R5: With loopback set, a receive read returns the buffered byte, clears the loopback-full flag and leaves `rx_ready` low.
- R6: With loopback clear, a transmit write raises that channel's `tx_valid` in the same cycle, with the written byte on `tx_data`. The device must take the byte; there is no back-pressure.
- R7: With loopback clear, a receive read returns `rx_data` and raises `rx_ready` for that cycle. The byte transfers only when `rx_valid` is also high. An empty queue reads 0x00.
- R8: Status bit 7 (clock shadow) and bit 6 (data shadow) read 1. When diagnostic is set, bit 6 reads 0 if data direction is 0, and bit 7 reads 0 if clock direction is 0.
- R9: Status bit 0 is the loopback-full flag in loopback mode and `rx_valid` otherwise. A channel requests an interrupt when its `dev_irq` is high, or when loopback is on and the loopback buffer is full. `irq_out` is the OR of both requests, and status bit 4 shows it in both windows.
- R10: Status bits 1, 2, 3 and 5 read 0. A write to the status offset changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | 9 | Byte address covering both windows |
| bus_rd | input | 1 | Read strobe, data returned same cycle |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, 0 when no read |
| rx_data | input | 2x8 | Head byte of each device receive queue |
| rx_valid | input | 2 | Queue non-empty, per channel |
| rx_ready | output | 2 | Pop request, per channel |
| tx_data | output | 2x8 | Byte to send, per channel |
| tx_valid | output | 2 | Send strobe, per channel |
| dev_irq | input | 2 | Device interrupt request, per channel |
| irq_out | output | 1 | Combined interrupt |

## Verification
A loopback-full flag that is wrong shows up in the same cycle: it changes `irq_out` and status bit 0, and the next receive read returns a stale byte or fails to drain the buffer. A control register that is corrupt also shows up at once. The shadow bits flip, and the wrong path is chosen between forwarding and buffering, so `tx_valid` or `rx_ready` pulses when it should stay quiet, or stays quiet when it should pulse. A decode fault that crosses windows shows as a control write in one window being read back in the other.

// File: rtl/ps2rf_pkg.sv
package ps2rf_pkg;
  typedef enum logic [1:0] {
    REG_ID_RST = 2'd0,
    REG_DATA   = 2'd1,
    REG_CTRL   = 2'd2,
    REG_STAT   = 2'd3
  } reg_sel_e;

  localparam int CTL_EN   = 0;
  localparam int CTL_LB   = 1;
  localparam int CTL_DIAG = 5;
  localparam int CTL_DDIR = 6;
  localparam int CTL_CDIR = 7;

  localparam int ST_RXNE  = 0;
  localparam int ST_TXNE  = 1;
  localparam int ST_TOERR = 2;
  localparam int ST_PERR  = 3;
  localparam int ST_IRQ   = 4;
  localparam int ST_RSVD  = 5;
  localparam int ST_DSHD  = 6;
  localparam int ST_CSHD  = 7;
endpackage

// File: rtl/ps2rf_addr_dec.sv
module ps2rf_addr_dec #(
  parameter int N_CH     = 2,
  parameter int WIN_BITS = 8,
  parameter int CH_BITS  = 1,
  localparam int ADDR_W  = WIN_BITS + CH_BITS
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [N_CH-1:0]   ch_sel,
  output ps2rf_pkg::reg_sel_e reg_sel
);
  logic [CH_BITS-1:0] ch_field;
  logic unused_addr;

  assign ch_field    = addr[ADDR_W-1:WIN_BITS];
  assign reg_sel     = ps2rf_pkg::reg_sel_e'(addr[3:2]);
  assign unused_addr = ^{addr[WIN_BITS-1:4], addr[1:0]};

  for (genvar g = 0; g < N_CH; g++) begin : g_sel
    assign ch_sel[g] = (ch_field == CH_BITS'(g));
  end
endmodule

// File: rtl/ps2rf_stat.sv
module ps2rf_stat #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] ctrl,
  input  logic          rx_nonempty,
  input  logic          irq_any,
  output logic [DW-1:0] stat
);
  import ps2rf_pkg::*;

  always_comb begin
    stat           = '0;
    stat[ST_RXNE]  = rx_nonempty;
    stat[ST_IRQ]   = irq_any;
    stat[ST_DSHD]  = !(ctrl[CTL_DIAG] && !ctrl[CTL_DDIR]);
    stat[ST_CSHD]  = !(ctrl[CTL_DIAG] && !ctrl[CTL_CDIR]);
  end
endmodule

// File: rtl/ps2rf_chan.sv
module ps2rf_chan #(
  parameter int DW     = 8,
  parameter int ID_VAL = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel,
  input  logic          rd,
  input  logic          wr,
  input  ps2rf_pkg::reg_sel_e reg_sel,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_valid,
  output logic          rx_ready,
  output logic [DW-1:0] tx_data,
  output logic          tx_valid,
  input  logic          dev_irq,
  input  logic          irq_any,
  output logic          req
);
  import ps2rf_pkg::*;

  logic [DW-1:0] ctrl_q;
  logic [DW-1:0] lb_byte_q;
  logic          lb_full_q;
  logic          lb_on;
  logic          wr_rst, wr_tx, wr_ctl, rd_rx;
  logic          rx_ne;
  logic [DW-1:0] stat_w;

  assign lb_on  = ctrl_q[CTL_LB];
  assign wr_rst = sel && wr && (reg_sel == REG_ID_RST);
  assign wr_tx  = sel && wr && (reg_sel == REG_DATA);
  assign wr_ctl = sel && wr && (reg_sel == REG_CTRL);
  assign rd_rx  = sel && rd && (reg_sel == REG_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      lb_byte_q <= '0;
      lb_full_q <= 1'b0;
    end else if (wr_rst) begin
      ctrl_q    <= '0;
      lb_byte_q <= '0;
      lb_full_q <= 1'b0;
    end else begin
      if (wr_ctl) ctrl_q <= wdata;
      if (wr_tx && lb_on) begin
        lb_byte_q <= wdata;
        lb_full_q <= 1'b1;
      end else if (rd_rx && lb_on) begin
        lb_full_q <= 1'b0;
      end
    end
  end

  assign tx_valid = wr_tx && !lb_on;
  assign tx_data  = wdata;
  assign rx_ready = rd_rx && !lb_on;
  assign rx_ne    = lb_on ? lb_full_q : rx_valid;
  assign req      = dev_irq || (lb_on && lb_full_q);

  ps2rf_stat #(.DW(DW)) u_stat (
    .ctrl        (ctrl_q),
    .rx_nonempty (rx_ne),
    .irq_any     (irq_any),
    .stat        (stat_w)
  );

  always_comb begin
    unique case (reg_sel)
      REG_ID_RST: rdata = DW'(ID_VAL);
      REG_DATA:   rdata = lb_on ? lb_byte_q : (rx_valid ? rx_data : '0);
      REG_CTRL:   rdata = ctrl_q;
      default:    rdata = stat_w;
    endcase
  end

  assert_lb_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_tx && lb_on) |=> lb_full_q);

  assert_lb_drain_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rx && lb_on && !wr_tx) |=> !lb_full_q);

  assert_rst_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_rst |=> (ctrl_q == '0 && !lb_full_q));

  assert_ctl_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctl |=> (ctrl_q == $past(wdata)));

  assert_unused_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_w[ST_TXNE] == 1'b0 && stat_w[ST_TOERR] == 1'b0 &&
     stat_w[ST_PERR] == 1'b0 && stat_w[ST_RSVD] == 1'b0));
endmodule

// File: rtl/ps2_dual_regfront.sv
module ps2_dual_regfront #(
  parameter int N_CH     = 2,
  parameter int DW       = 8,
  parameter int WIN_BITS = 8,
  localparam int CH_BITS = (N_CH > 1) ? $clog2(N_CH) : 1,
  localparam int ADDR_W  = WIN_BITS + CH_BITS
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic                     bus_rd,
  input  logic                     bus_wr,
  input  logic [DW-1:0]            bus_wdata,
  output logic [DW-1:0]            bus_rdata,
  input  logic [N_CH-1:0][DW-1:0]  rx_data,
  input  logic [N_CH-1:0]          rx_valid,
  output logic [N_CH-1:0]          rx_ready,
  output logic [N_CH-1:0][DW-1:0]  tx_data,
  output logic [N_CH-1:0]          tx_valid,
  input  logic [N_CH-1:0]          dev_irq,
  output logic                     irq_out
);
  logic [N_CH-1:0]         ch_sel;
  ps2rf_pkg::reg_sel_e     reg_sel;
  logic [N_CH-1:0][DW-1:0] ch_rdata;
  logic [N_CH-1:0]         ch_req;
  logic [DW-1:0]           rd_mux;

  ps2rf_addr_dec #(.N_CH(N_CH), .WIN_BITS(WIN_BITS), .CH_BITS(CH_BITS)) u_dec (
    .addr    (bus_addr),
    .ch_sel  (ch_sel),
    .reg_sel (reg_sel)
  );

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    ps2rf_chan #(.DW(DW), .ID_VAL(g)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel      (ch_sel[g]),
      .rd       (bus_rd),
      .wr       (bus_wr),
      .reg_sel  (reg_sel),
      .wdata    (bus_wdata),
      .rdata    (ch_rdata[g]),
      .rx_data  (rx_data[g]),
      .rx_valid (rx_valid[g]),
      .rx_ready (rx_ready[g]),
      .tx_data  (tx_data[g]),
      .tx_valid (tx_valid[g]),
      .dev_irq  (dev_irq[g]),
      .irq_any  (irq_out),
      .req      (ch_req[g])
    );
  end

  assign irq_out = |ch_req;

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < N_CH; i++) begin
      if (ch_sel[i]) rd_mux = rd_mux | ch_rdata[i];
    end
  end

  assign bus_rdata = bus_rd ? rd_mux : '0;

  assert_one_window_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_sel));

  assert_irq_out_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|dev_irq) |-> irq_out);

  assert_strobe_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tx_valid | rx_ready));
endmodule

// File: tb/ps2_dual_regfront_test.sv
`timescale 1ns/1ps
module ps2_dual_regfront_test;
  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [8:0]      bus_addr = '0;
  logic            bus_rd = 1'b0;
  logic            bus_wr = 1'b0;
  logic [7:0]      bus_wdata = '0;
  logic [7:0]      bus_rdata;
  logic [1:0][7:0] rx_data = '0;
  logic [1:0]      rx_valid = '0;
  logic [1:0]      rx_ready;
  logic [1:0][7:0] tx_data;
  logic [1:0]      tx_valid;
  logic [1:0]      dev_irq = '0;
  logic            irq_out;

  int vectors = 0;
  int miscompares = 0;
  logic [1:0]      cap_txv, cap_rxr;
  logic [1:0][7:0] cap_txd;
  logic [7:0]      rv;

  always #5 clk = ~clk;

  ps2_dual_regfront uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .tx_data(tx_data), .tx_valid(tx_valid), .dev_irq(dev_irq),
    .irq_out(irq_out)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic bus_write(input logic [8:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    #2;
    cap_txv = tx_valid; cap_txd = tx_data;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [8:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #2;
    d = bus_rdata; cap_rxr = rx_ready;
    @(posedge clk); #1;
    bus_rd = 1'b0;
  endtask

  task automatic t_reset_state();
    bus_read(9'h000, rv); check("R2 kbd id", rv, 8'h00);
    bus_read(9'h100, rv); check("R2 mouse id", rv, 8'h01);
    bus_read(9'h008, rv); check("R3 kbd ctrl after reset", rv, 8'h00);
    bus_read(9'h10C, rv); check("R8 mouse status after reset", rv, 8'hC0);
    check("R9 irq after reset", irq_out, 1'b0);
  endtask

  task automatic t_decode();
    bus_write(9'h0FB, 8'hA1);
    bus_read(9'h008, rv); check("R1 aliased ctrl write", rv, 8'hA1);
    bus_read(9'h108, rv); check("R1 other window untouched", rv, 8'h00);
    bus_write(9'h008, 8'h00);
  endtask

  task automatic t_tx_forward();
    bus_write(9'h004, 8'h5A);
    check("R6 kbd tx_valid", cap_txv, 2'b01);
    check("R6 kbd tx_data", cap_txd[0], 8'h5A);
    bus_write(9'h104, 8'hC3);
    check("R6 mouse tx_valid", cap_txv, 2'b10);
    check("R6 mouse tx_data", cap_txd[1], 8'hC3);
  endtask

  task automatic t_rx_queue();
    rx_data[1] = 8'h3C; rx_valid[1] = 1'b1;
    bus_read(9'h10C, rv); check("R9 status rx not empty", rv, 8'hC1);
    bus_read(9'h104, rv); check("R7 rx byte", rv, 8'h3C);
    check("R7 rx_ready pulse", cap_rxr, 2'b10);
    rx_valid[1] = 1'b0;
    bus_read(9'h104, rv); check("R7 empty queue reads zero", rv, 8'h00);
    bus_read(9'h10C, rv); check("R9 status rx empty", rv, 8'hC0);
  endtask

  task automatic t_loopback();
    bus_write(9'h008, 8'h02);
    bus_write(9'h004, 8'h77);
    check("R4 no tx in loopback", cap_txv, 2'b00);
    bus_read(9'h00C, rv); check("R4 status full in loopback", rv, 8'hD1);
    bus_read(9'h10C, rv); check("R9 irq seen in other window", rv, 8'hD0);
    check("R9 irq_out from loopback", irq_out, 1'b1);
    bus_read(9'h004, rv); check("R5 loopback byte", rv, 8'h77);
    check("R5 no pop in loopback", cap_rxr, 2'b00);
    bus_read(9'h00C, rv); check("R5 flag cleared", rv, 8'hC0);
    check("R9 irq_out dropped", irq_out, 1'b0);
  endtask

  task automatic t_shadow();
    bus_write(9'h008, 8'h20); bus_read(9'h00C, rv); check("R8 diag both low", rv, 8'h00);
    bus_write(9'h008, 8'h60); bus_read(9'h00C, rv); check("R8 data dir set", rv, 8'h40);
    bus_write(9'h008, 8'hA0); bus_read(9'h00C, rv); check("R8 clock dir set", rv, 8'h80);
    bus_write(9'h008, 8'h40); bus_read(9'h00C, rv); check("R8 no diag", rv, 8'hC0);
  endtask

  task automatic t_dev_irq();
    dev_irq = 2'b10;
    #1; check("R9 irq_out from device", irq_out, 1'b1);
    bus_read(9'h00C, rv); check("R9 kbd status shows mouse irq", rv, 8'hD0);
    dev_irq = 2'b00;
    #1; check("R9 irq_out clears", irq_out, 1'b0);
  endtask

  task automatic t_chan_reset();
    bus_write(9'h108, 8'h03);
    bus_write(9'h104, 8'h11);
    bus_read(9'h10C, rv); check("R3 pre-reset full", rv, 8'hD1);
    bus_write(9'h100, 8'h00);
    bus_read(9'h108, rv); check("R3 reset write clears ctrl", rv, 8'h00);
    bus_read(9'h10C, rv); check("R3 reset write clears flag", rv, 8'hC0);
  endtask

  task automatic t_status_write();
    bus_write(9'h008, 8'h81);
    bus_write(9'h00C, 8'hFF);
    bus_read(9'h008, rv); check("R10 status write leaves ctrl", rv, 8'h81);
    bus_read(9'h00C, rv); check("R10 unused bits zero", rv, 8'hC0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset_state();
    t_decode();
    t_tx_forward();
    t_rx_queue();
    t_loopback();
    t_shadow();
    t_dev_irq();
    t_chan_reset();
    t_status_write();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    vectors++;
    miscompares++;
    $display("FAIL watchdog (all requirements): got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule